// File: doc/BRIEF.md
# Quasi-Random Pattern Sync Checker

This block watches a received serial bit stream, one bit per receive clock, and decides whether it carries the quasi-random test sequence. The sequence is a 2^20-1 pseudo-random pattern with limited zero runs for T1 lines, or an inverted 2^15-1 pattern for E1 lines. A line-type input selects between them. While it is searching, the block loads its local shift register straight from the received bits. Once the register is full, it compares each new received bit against the bit it predicts and counts mismatches over 128-bit windows.

A window that ends with fewer than four mismatches declares pattern sync. After that the local register runs free, so a corrupted bit is counted as an error and does not spoil later predictions. The single status output is high while the block is in sync. It drops low for one cycle for every bit in error. If a window in sync collects four or more errors, the block drops sync and starts loading again. An interrupt output pulses on every change of the status output when interrupts are enabled. Clearing the enable input returns the block to its idle state.

Top module: `qrss_sync_checker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sync_ok` and `irq` are 0.
- R2: T1 mode (`line_e1`=0): the raw sequence obeys s[n] = s[n-17] XOR s[n-20]. The transmitted bit is s[n] OR'ed with 1 whenever the 14 raw bits before it were all 0. While loading, the received bit itself is taken as the raw bit. A clean T1 stream is tracked with no errors.
- R3: E1 mode (`line_e1`=1): the raw sequence obeys s[n] = s[n-14] XOR s[n-15], and the transmitted bit is NOT s[n]. While loading, the inverted received bit is taken as the raw bit. A clean E1 stream is tracked with no errors.
- R4: After enable or loss of sync, the register first takes in 20 bits (T1) or 15 bits (E1) without comparison. Then 128-bit windows of comparisons follow. Sync is declared, and `sync_ok` rises in the cycle after the last bit of a window, when that window held fewer than 4 mismatches and the used part of the register is not all zeros.
- R5: A window that fails during the search starts a new 128-bit window with the error count cleared. The register keeps taking in received bits.
- R6: In sync, each mismatching bit drives `sync_ok` low for exactly the next cycle. The register advances on its own prediction, so one error does not cause further errors.
- R7: In sync, a 128-bit window with 4 or more mismatches drops sync. `sync_ok` then stays low and the loading of R4 starts again.
- R8: When `irq_en`=1 and `en`=1, `irq` is high for exactly the cycles in which `sync_ok` has just changed value. When `irq_en`=0, `irq` stays 0.
- R9: While `en`=0, the next cycle shows `sync_ok`=0 and `irq`=0, and the search restarts from an empty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received data bit, one per clock |
| line_e1 | input | 1 | Sequence select: 0 = T1 variant, 1 = E1 variant |
| en | input | 1 | Checker enable |
| irq_en | input | 1 | Interrupt enable |
| sync_ok | output | 1 | Sync status; low pulse per error while in sync |
| irq | output | 1 | Pulse on each change of `sync_ok` |

## Verification
The last bit of a window can also be a mismatching bit, so the window verdict and the one-cycle error pulse fall in the same cycle. In sync, a correct design must then choose between a pulse followed by recovery (fewer than four errors in total) and a lasting drop (four or more). The bench provokes this with error bursts and with random error rates high enough that errors land on window boundaries. Every cycle it compares `sync_ok` and `irq` against a bench model built from the requirements, including the two interrupt cycles that each error pulse produces.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_e;

    localparam int DEF_T1_LEN   = 20;
    localparam int DEF_T1_TAP   = 17;
    localparam int DEF_T1_ZRUN  = 14;
    localparam int DEF_E1_LEN   = 15;
    localparam int DEF_E1_TAP   = 14;
    localparam int DEF_WIN_BITS = 128;
    localparam int DEF_ERR_LIM  = 4;

endpackage

// File: rtl/qrss_predict.sv
// Combinational prediction of the next received bit from the local register.
module qrss_predict #(
    parameter int REG_W  = 20,
    parameter int FILL_W = 5,
    parameter int T1_LEN = 20,
    parameter int T1_TAP = 17,
    parameter int T1_ZRUN = 14,
    parameter int E1_LEN = 15,
    parameter int E1_TAP = 14
) (
    input  logic [REG_W-1:0]  shreg,
    input  logic              line_e1,
    input  logic              rx_bit,
    output logic              exp_bit,
    output logic              raw_pred,
    output logic              seed_raw,
    output logic              seed_live,
    output logic [FILL_W-1:0] need_len
);
    logic t1_raw, e1_raw, t1_force;

    assign t1_raw = shreg[T1_TAP-1] ^ shreg[T1_LEN-1];
    assign e1_raw = shreg[E1_TAP-1] ^ shreg[E1_LEN-1];

    generate
        if (T1_ZRUN > 0) begin : g_zrun
            assign t1_force = ~|shreg[T1_ZRUN-1:0];
        end else begin : g_nozrun
            assign t1_force = 1'b0;
        end
    endgenerate

    always_comb begin
        if (line_e1) begin
            raw_pred  = e1_raw;
            exp_bit   = ~e1_raw;
            seed_raw  = ~rx_bit;
            seed_live = |shreg[E1_LEN-1:0];
            need_len  = FILL_W'(E1_LEN);
        end else begin
            raw_pred  = t1_raw;
            exp_bit   = t1_raw | t1_force;
            seed_raw  = rx_bit;
            seed_live = |shreg[T1_LEN-1:0];
            need_len  = FILL_W'(T1_LEN);
        end
    end
endmodule

// File: rtl/qrss_window.sv
// Window position and saturating error total for the current bit.
module qrss_window #(
    parameter int WIN_BITS = 128,
    parameter int ERR_LIM  = 4,
    parameter int WIN_W    = 7,
    parameter int ERR_W    = 3
) (
    input  logic [WIN_W-1:0] win_cnt,
    input  logic [ERR_W-1:0] err_cnt,
    input  logic             mism,
    output logic             win_last,
    output logic [ERR_W-1:0] err_total,
    output logic             too_many
);
    always_comb begin
        win_last = (win_cnt == WIN_W'(WIN_BITS - 1));
        if (err_cnt >= ERR_W'(ERR_LIM)) begin
            err_total = ERR_W'(ERR_LIM);
        end else begin
            err_total = err_cnt + ERR_W'(mism);
        end
        too_many = (err_total >= ERR_W'(ERR_LIM));
    end
endmodule

// File: rtl/qrss_sync_checker.sv
module qrss_sync_checker
    import qrss_pkg::*;
#(
    parameter int T1_LEN   = DEF_T1_LEN,
    parameter int T1_TAP   = DEF_T1_TAP,
    parameter int T1_ZRUN  = DEF_T1_ZRUN,
    parameter int E1_LEN   = DEF_E1_LEN,
    parameter int E1_TAP   = DEF_E1_TAP,
    parameter int WIN_BITS = DEF_WIN_BITS,
    parameter int ERR_LIM  = DEF_ERR_LIM
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic line_e1,
    input  logic en,
    input  logic irq_en,
    output logic sync_ok,
    output logic irq
);
    localparam int REG_W  = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;
    localparam int FILL_W = $clog2(REG_W + 1);
    localparam int WIN_W  = $clog2(WIN_BITS);
    localparam int ERR_W  = $clog2(ERR_LIM + 1);

    typedef struct packed {
        sync_st_e          st;
        logic [FILL_W-1:0] fill;
        logic [WIN_W-1:0]  win;
        logic [ERR_W-1:0]  errs;
        logic [REG_W-1:0]  shreg;
        logic              ok;
        logic              irq;
    } core_t;

    core_t cur_q, nxt_d;

    logic              exp_bit, raw_pred, seed_raw, seed_live;
    logic [FILL_W-1:0] need_len;
    logic              mism, win_last, too_many;
    logic [ERR_W-1:0]  err_total;

    qrss_predict #(
        .REG_W(REG_W), .FILL_W(FILL_W),
        .T1_LEN(T1_LEN), .T1_TAP(T1_TAP), .T1_ZRUN(T1_ZRUN),
        .E1_LEN(E1_LEN), .E1_TAP(E1_TAP)
    ) u_predict (
        .shreg(cur_q.shreg), .line_e1(line_e1), .rx_bit(rx_bit),
        .exp_bit(exp_bit), .raw_pred(raw_pred), .seed_raw(seed_raw),
        .seed_live(seed_live), .need_len(need_len)
    );

    assign mism = rx_bit ^ exp_bit;

    qrss_window #(
        .WIN_BITS(WIN_BITS), .ERR_LIM(ERR_LIM), .WIN_W(WIN_W), .ERR_W(ERR_W)
    ) u_window (
        .win_cnt(cur_q.win), .err_cnt(cur_q.errs), .mism(mism),
        .win_last(win_last), .err_total(err_total), .too_many(too_many)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!en) begin
            nxt_d.st    = ST_HUNT;
            nxt_d.fill  = '0;
            nxt_d.win   = '0;
            nxt_d.errs  = '0;
            nxt_d.shreg = '0;
            nxt_d.ok    = 1'b0;
        end else if (cur_q.st == ST_HUNT) begin
            // searching: load received bits as raw sequence bits
            nxt_d.shreg = {cur_q.shreg[REG_W-2:0], seed_raw};
            nxt_d.ok    = 1'b0;
            if (cur_q.fill < need_len) begin
                nxt_d.fill = cur_q.fill + FILL_W'(1);
            end else if (win_last) begin
                nxt_d.win  = '0;
                nxt_d.errs = '0;
                if (!too_many && seed_live) begin
                    nxt_d.st = ST_LOCK;
                    nxt_d.ok = 1'b1;
                end
            end else begin
                nxt_d.win  = cur_q.win + WIN_W'(1);
                nxt_d.errs = err_total;
            end
        end else begin
            // in sync: register runs on its own prediction
            nxt_d.shreg = {cur_q.shreg[REG_W-2:0], raw_pred};
            nxt_d.ok    = ~mism;
            if (win_last) begin
                nxt_d.win  = '0;
                nxt_d.errs = '0;
                if (too_many) begin
                    nxt_d.st   = ST_HUNT;
                    nxt_d.fill = '0;
                    nxt_d.ok   = 1'b0;
                end
            end else begin
                nxt_d.win  = cur_q.win + WIN_W'(1);
                nxt_d.errs = err_total;
            end
        end
        nxt_d.irq = en & irq_en & (nxt_d.ok != cur_q.ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_HUNT, fill: '0, win: '0, errs: '0,
                       shreg: '0, ok: 1'b0, irq: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sync_ok = cur_q.ok;
    assign irq     = cur_q.irq;
endmodule

// File: rtl/qrss_sync_chk.sv
module qrss_sync_chk #(
    parameter int ERR_LIM = 4,
    parameter int ERR_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ien,
    input logic             sync_ok,
    input logic             irq,
    input logic             lock_q,
    input logic [ERR_W-1:0] err_q
);
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sync_ok && !irq));

    assert_irq_only_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sync_ok != $past(sync_ok)));

    assert_irq_when_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(ien) && (sync_ok != $past(sync_ok))) |-> irq);

    assert_lock_raises_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> sync_ok);

    assert_loss_drops_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> !sync_ok);

    assert_ok_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |-> lock_q);

    assert_err_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= ERR_W'(ERR_LIM));
endmodule

bind qrss_sync_checker qrss_sync_chk #(
    .ERR_LIM(ERR_LIM), .ERR_W(ERR_W)
) u_sync_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .ien(irq_en),
    .sync_ok(sync_ok), .irq(irq),
    .lock_q(cur_q.st == qrss_pkg::ST_LOCK), .err_q(cur_q.errs)
);

// File: tb/test_qrss_sync_checker.sv
`timescale 1ns/1ps
module test_qrss_sync_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, line_e1 = 1'b0, en = 1'b0, irq_en = 1'b0;
    logic sync_ok, irq;

    always #10 clk = ~clk;

    qrss_sync_checker i_qrss_sync_checker (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .line_e1(line_e1),
        .en(en), .irq_en(irq_en), .sync_ok(sync_ok), .irq(irq)
    );

    int compared = 0, mismatched = 0;
    bit done = 0;

    // stimulus controls
    bit c_en = 0, c_ien = 0, c_e1 = 0;
    int src = 0; // 0 pattern, 1 noise, 2 constant ones
    logic [19:0] gen_s = 20'h5A3C1;

    // bench model state
    bit m_lock = 0, m_ok = 0, m_irq = 0;
    int m_fill = 0, m_win = 0, m_err = 0;
    logic [19:0] m_reg = '0;

    task automatic chk(input logic act, input logic expv, input string tag);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic gen_next(input bit e1);
        logic raw, o;
        if (e1) begin
            raw = gen_s[13] ^ gen_s[14];
            o = ~raw;
        end else begin
            raw = gen_s[16] ^ gen_s[19];
            o = raw | (gen_s[13:0] == 14'd0);
        end
        gen_s = {gen_s[18:0], raw};
        return o;
    endfunction

    task automatic model_step(input logic rxv);
        logic t1raw, e1raw, frc, raw, expb, live, mis, seed;
        int len, tot;
        bit nok;
        if (!c_en) begin
            m_lock = 0; m_fill = 0; m_win = 0; m_err = 0; m_reg = '0;
            nok = 0;
        end else begin
            t1raw = m_reg[16] ^ m_reg[19];
            e1raw = m_reg[13] ^ m_reg[14];
            frc   = (m_reg[13:0] == 14'd0);
            raw   = c_e1 ? e1raw : t1raw;
            expb  = c_e1 ? ~e1raw : (t1raw | frc);
            len   = c_e1 ? 15 : 20;
            live  = c_e1 ? (|m_reg[14:0]) : (|m_reg);
            mis   = rxv ^ expb;
            seed  = c_e1 ? ~rxv : rxv;
            tot   = (m_err + int'(mis) > 4) ? 4 : m_err + int'(mis);
            nok = 0;
            if (!m_lock) begin
                m_reg = {m_reg[18:0], seed};
                if (m_fill < len) m_fill++;
                else if (m_win == 127) begin
                    m_win = 0; m_err = 0;
                    if (tot < 4 && live) begin m_lock = 1; nok = 1; end
                end else begin m_win++; m_err = tot; end
            end else begin
                m_reg = {m_reg[18:0], raw};
                nok = !mis;
                if (m_win == 127) begin
                    m_win = 0; m_err = 0;
                    if (tot >= 4) begin m_lock = 0; m_fill = 0; nok = 0; end
                end else begin m_win++; m_err = tot; end
            end
        end
        m_irq = c_en && c_ien && (nok != m_ok);
        m_ok = nok;
    endtask

    // one bit period; flip injects an error into the pattern bit
    task automatic cyc(input bit flip, input string tag);
        logic b;
        @(negedge clk);
        case (src)
            0: b = gen_next(c_e1) ^ flip;
            1: b = 1'($urandom_range(0, 1));
            default: b = 1'b1;
        endcase
        rx_bit = b; en = c_en; irq_en = c_ien; line_e1 = c_e1;
        model_step(b);
        @(posedge clk);
        #2;
        chk(sync_ok, m_ok, tag);
        chk(irq, m_irq, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, tag);
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd4242);
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(sync_ok, 1'b0, "R1 reset sync_ok");
        chk(irq, 1'b0, "R1 reset irq");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(sync_ok, 1'b0, "R1 after reset");

        // R2/R4: clean T1 stream locks after fill + one window
        c_en = 1; c_ien = 1; c_e1 = 0; src = 0;
        run(20 + 127, "R4 hunt");
        chk(sync_ok, 1'b0, "R4 not before window end");
        cyc(1'b0, "R4 lock cycle");
        chk(sync_ok, 1'b1, "R4 locked");
        chk(irq, 1'b1, "R8 irq on lock");
        run(3000, "R2 T1 tracking");

        // R6: isolated errors pulse once each
        for (int k = 0; k < 3; k++) begin
            run(40, "R6 gap");
            cyc(1'b1, "R6 error");
            chk(sync_ok, 1'b0, "R6 pulse low");
            cyc(1'b0, "R6 recover");
            chk(sync_ok, 1'b1, "R6 back high");
        end

        // R7: burst of errors drops sync
        for (int k = 0; k < 6; k++) cyc(1'b1, "R7 burst");
        run(140, "R7 after loss");
        run(300, "R5 reseed");

        // R9: disable clears status
        c_en = 0;
        cyc(1'b0, "R9 disable");
        chk(sync_ok, 1'b0, "R9 cleared");
        chk(irq, 1'b0, "R9 no irq");
        run(5, "R9 idle");

        // R3: E1 stream
        c_e1 = 1; c_en = 1;
        run(15 + 128 + 400, "R3 E1 tracking");
        chk(sync_ok, 1'b1, "R3 E1 locked");

        // R8: interrupts masked
        c_ien = 0;
        cyc(1'b1, "R8 masked err");
        chk(irq, 1'b0, "R8 masked irq");
        run(20, "R8 masked");
        c_ien = 1;

        // R4 guard: all-ones E1 input never locks
        c_en = 0; cyc(1'b0, "R9 off");
        c_en = 1; src = 2;
        run(600, "R4 all-ones");
        chk(sync_ok, 1'b0, "R4 no lock on ones");

        // R5: noise never locks, then clean pattern locks
        src = 1; c_e1 = 0;
        c_en = 0; cyc(1'b0, "R9 off");
        c_en = 1;
        run(800, "R5 noise");
        src = 0;
        run(600, "R5 relock");

        // random mix
        for (int blk = 0; blk < 60; blk++) begin
            int pct;
            bit ne1;
            pct = $urandom_range(0, 4);
            pct = (pct == 0) ? 0 : (pct == 1) ? 1 : (pct == 2) ? 2 : (pct == 3) ? 4 : 12;
            c_ien = 1'($urandom_range(0, 3) != 0);
            ne1 = 1'($urandom_range(0, 1));
            if (ne1 != c_e1) begin
                c_en = 0; cyc(1'b0, "R9 switch");
                c_e1 = ne1; c_en = 1;
            end
            for (int i = 0; i < 700; i++) begin
                if ($urandom_range(0, 999) == 0) c_en = ~c_en;
                cyc(1'($urandom_range(0, 99) < pct), "R6 R7 random");
            end
            c_en = 1;
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule